// File: doc/BRIEF.md
# Serial Trigger Frame Transmitter

The block sends one trigger record as a fixed serial frame on a single output line. When a start request arrives while the block is idle, it captures a 24-bit trigger number and a 2-bit status value. It then drives a 37-bit frame onto the line and holds each bit for a fixed number of clock cycles.

The frame is built in this order:

1. A low start bit.
2. A four-bit marker 1,0,1,0.
3. The trigger number, most significant bit first.
4. The two status bits.
5. An even-parity bit.
6. A second 1,0,1,0 marker.
7. A high stop bit.

Between frames the line rests high. The busy output stays high while a frame is going out. A one-cycle done pulse marks the end of the frame. Start requests that arrive while busy have no effect. The captured values protect the frame in flight against later changes at the data inputs.

Top module: `trig_frame_tx`

## Requirements
- R1: A synchronous reset, including one applied in the middle of a frame, leaves line_o = 1, busy_o = 0 and done_o = 0 from the next clock on.
- R2: While idle, line_o is 1 and done_o is 0.
- R3: A start_i sampled high while idle is accepted. From the next cycle, busy_o is 1 and line_o carries frame bit 0, the start bit, which is 0.
- R4: Frame bits 1 to 4 (bit 0 goes out first) are 1,0,1,0.
- R5: Frame bits 5 to 28 carry num_i[23] down to num_i[0].
- R6: Frame bits 29 and 30 carry stat_i[1] and then stat_i[0].
- R7: Frame bit 31 makes the XOR of the 24 number bits, the 2 status bits and itself equal 0.
- R8: Frame bits 32 to 35 are 1,0,1,0, and frame bit 36, the stop bit, is 1.
- R9: Each frame bit is held on line_o for exactly CYC_PER_BIT cycles (default 4). busy_o stays 1 for all 37 × CYC_PER_BIT cycles.
- R10: In the cycle after the stop bit has been held for its full period, done_o is 1 for exactly one cycle and busy_o returns to 0.
- R11: The number and status are captured when the request is accepted. Changes on num_i and stat_i during a frame do not alter it.
- R12: A start_i held while busy is ignored. The frame in flight is unchanged, and no second frame follows the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the block; one line bit spans CYC_PER_BIT of its cycles |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to send a frame |
| num_i | input | 24 | Trigger number to send |
| stat_i | input | 2 | Status field to send |
| line_o | output | 1 | Serial line, high at rest |
| busy_o | output | 1 | High while a frame is being sent |
| done_o | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The assertions take for granted only that start_i, num_i and stat_i are valid at every rising edge. They expect no particular protocol on start_i: a request may be held, repeated or raised while busy. The stimulus changes every input only on falling edges. During the noisy frames it raises start_i and changes num_i and stat_i at random while busy, so the acceptance and hold properties are exercised under input activity. Reset is raised on a falling edge, in the middle of a frame as well as at startup.

// File: rtl/trig_frame_pkg.sv
package trig_frame_pkg;

    // Width of each marker (before and after the payload)
    localparam int MARK_W = 4;
    localparam logic [MARK_W-1:0] MARK_PAT = 4'b1010;

    // Total frame length for a given payload layout
    function automatic int frame_len(input int num_w, input int stat_w);
        return 1 + MARK_W + num_w + stat_w + 1 + MARK_W + 1;
    endfunction

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

endpackage

// File: rtl/trig_frame_build.sv
module trig_frame_build
    import trig_frame_pkg::*;
#(
    parameter int NUM_W  = 24,
    parameter int STAT_W = 2,
    parameter int LEN    = frame_len(NUM_W, STAT_W)
) (
    input  logic [NUM_W-1:0]  num_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic [LEN-1:0]    frame_o
);

    logic par;

    // Even parity over number and status
    assign par = ^{num_i, stat_i};

    // Bit LEN-1 goes out first
    assign frame_o = {1'b0, MARK_PAT, num_i, stat_i, par, MARK_PAT, 1'b1};

endmodule

// File: rtl/trig_frame_timer.sv
module trig_frame_timer #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic clear_i,
    output logic tick_o,
    output logic first_o
);

    localparam int CNT_W = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign tick_o  = run_i && (cnt_q == LAST);
    assign first_o = (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (run_i) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R9: the phase counter never leaves its range
    assert_cnt_range_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/trig_frame_tx.sv
module trig_frame_tx
    import trig_frame_pkg::*;
#(
    parameter int NUM_W       = 24,
    parameter int STAT_W      = 2,
    parameter int CYC_PER_BIT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [NUM_W-1:0]  num_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic              line_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int LEN   = frame_len(NUM_W, STAT_W);
    localparam int IDX_W = $clog2(LEN);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LEN - 1);

    typedef struct packed {
        tx_state_e        st;
        logic [LEN-1:0]   sh;
        logic [IDX_W-1:0] idx;
        logic             done;
    } tx_regs_t;

    tx_regs_t d, q;

    logic [LEN-1:0] frame;
    logic           accept;
    logic           tick;
    logic           first;

    trig_frame_build #(
        .NUM_W (NUM_W),
        .STAT_W(STAT_W),
        .LEN   (LEN)
    ) u_build (
        .num_i  (num_i),
        .stat_i (stat_i),
        .frame_o(frame)
    );

    trig_frame_timer #(
        .CYC(CYC_PER_BIT)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run_i  (q.st == ST_SEND),
        .clear_i(accept),
        .tick_o (tick),
        .first_o(first)
    );

    assign accept = start_i && (q.st == ST_IDLE);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    d.st  = ST_SEND;
                    d.sh  = frame;
                    d.idx = '0;
                end
            end
            ST_SEND: begin
                if (tick) begin
                    if (q.idx == IDX_LAST) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.sh   = '1;
                    end else begin
                        d.sh  = {q.sh[LEN-2:0], 1'b1};
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st   <= ST_IDLE;
            q.sh   <= '1;
            q.idx  <= '0;
            q.done <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign line_o = (q.st == ST_SEND) ? q.sh[LEN-1] : 1'b1;
    assign busy_o = (q.st == ST_SEND);
    assign done_o = q.done;

    // R3: an accepted request starts with the low start bit
    assert_accept_start_R3: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && !line_o));

    // R2: line rests high while idle
    assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> line_o);

    // R9: the line holds inside a bit period
    assert_bit_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !first) |-> $stable(line_o));

    // R10: done is a single pulse
    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R10: done marks the end of a frame
    assert_done_end_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

endmodule

// File: tb/trig_frame_tx_test.sv
module trig_frame_tx_test;

    localparam int C   = 4;
    localparam int LEN = 37;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [23:0] num_i = '0;
    logic [1:0]  stat_i = '0;
    logic        line_o, busy_o, done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    trig_frame_tx #(.NUM_W(24), .STAT_W(2), .CYC_PER_BIT(C)) uut (
        .clk    (clk),
        .rst    (rst),
        .start_i(start_i),
        .num_i  (num_i),
        .stat_i (stat_i),
        .line_o (line_o),
        .busy_o (busy_o),
        .done_o (done_o)
    );

    function automatic logic exp_bit(input int k, input logic [23:0] n, input logic [1:0] s);
        if (k == 0) return 1'b0;                        // R3 start bit
        if (k <= 4) return logic'((k % 2) == 1);        // R4 marker
        if (k <= 28) return n[23 - (k - 5)];            // R5 number
        if (k <= 30) return s[1 - (k - 29)];            // R6 status
        if (k == 31) return ^{n, s};                    // R7 parity
        if (k <= 35) return logic'(((k - 32) % 2) == 0); // R8 marker
        return 1'b1;                                    // R8 stop
    endfunction

    function automatic string tag_of(input int k);
        if (k == 0) return "R3";
        if (k <= 4) return "R4";
        if (k <= 28) return "R5";
        if (k <= 30) return "R6";
        if (k == 31) return "R7";
        return "R8";
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_frame(input logic [23:0] n, input logic [1:0] s, input bit noisy);
        @(negedge clk);
        chk(busy_o == 1'b0, "R3 idle before request", busy_o, 0);
        start_i = 1'b1;
        num_i = n;
        stat_i = s;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < LEN; k++) begin
            for (int c = 0; c < C; c++) begin
                chk(line_o == exp_bit(k, n, s), tag_of(k), line_o, exp_bit(k, n, s));
                chk(busy_o == 1'b1, "R9 busy during frame", busy_o, 1);
                if (noisy) begin
                    // R11 and R12: input activity while busy
                    num_i = 24'($urandom);
                    stat_i = 2'($urandom);
                    start_i = 1'($urandom);
                end
                @(negedge clk);
            end
        end
        start_i = 1'b0;
        chk(done_o == 1'b1, "R10 done pulse", done_o, 1);
        chk(busy_o == 1'b0, "R10 busy falls", busy_o, 0);
        chk(line_o == 1'b1, "R8 line back high", line_o, 1);
        @(negedge clk);
        chk(done_o == 1'b0, "R10 done single", done_o, 0);
        chk(busy_o == 1'b0, "R12 no extra frame", busy_o, 0);
        chk(line_o == 1'b1, "R2 idle high", line_o, 1);
    endtask

    initial begin
        void'($urandom(32'd4177));
        repeat (3) @(negedge clk);
        chk(line_o == 1'b1, "R1 reset line", line_o, 1);
        chk(busy_o == 1'b0, "R1 reset busy", busy_o, 0);
        chk(done_o == 1'b0, "R1 reset done", done_o, 0);
        rst = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(line_o == 1'b1 && done_o == 1'b0, "R2 idle", line_o, 1);
        end
        run_frame(24'h000000, 2'b00, 1'b0);
        run_frame(24'hFFFFFF, 2'b11, 1'b0);
        run_frame(24'h800001, 2'b01, 1'b1);
        run_frame(24'h000001, 2'b10, 1'b1);
        for (int i = 0; i < 24; i++) begin
            run_frame(24'($urandom), 2'($urandom), 1'($urandom));
        end
        // R1: reset in the middle of a frame
        @(negedge clk);
        start_i = 1'b1;
        num_i = 24'h5A5A5A;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1 mid-frame reset busy", busy_o, 0);
        chk(line_o == 1'b1, "R1 mid-frame reset line", line_o, 1);
        chk(done_o == 1'b0, "R1 mid-frame reset done", done_o, 0);
        rst = 1'b0;
        run_frame(24'h123456, 2'b10, 1'b0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule